// File: doc/BRIEF.md
# Serial Input Sampling Delay Calibrator

This block finds a workable sampling delay for a serial input link. Its delay-code output selects one of four input delay settings, from code 0 up to code 3, which add 0, 2, 4 or 6 ns to the input path. After a start pulse the block tries each code in increasing order. For each code it waits a short settling time and then asks an external agent to run one read test. The block compares the 16-bit value that comes back with a fixed pattern. Each match sets the bit for that code in a 4-bit pass mask.

When all four codes have been tried, the block picks one final code from the pass mask. A single pass is taken as it is. Two adjacent passes choose the setting on the edge of the delay range, or the lower of the two if neither is on an edge. Three passes choose the middle code. Four passes choose code 1. A mask that is empty, or whose passes do not form one contiguous run, is reported as an error.

The sequencer has four states:
- `ST_IDLE` waits for start.
- `ST_SETTLE` lets the applied code settle for a fixed number of cycles.
- `ST_REQ` holds the read-test request until the agent reports done.
- `ST_DECIDE` decodes the mask and publishes the result.

The state transitions are:
- `ST_IDLE` → `ST_SETTLE` on start.
- `ST_SETTLE` → `ST_REQ` when the settle timer expires.
- `ST_REQ` → `ST_SETTLE` on a test response for codes 0 to 2.
- `ST_REQ` → `ST_DECIDE` on the test response for code 3.
- `ST_DECIDE` → `ST_IDLE` unconditionally.

Top module: `sdly_cal`

## Requirements
- R1: After reset, `done_o`, `err_o`, `rt_req_o`, `dly_code_o` and `sel_code_o` are all zero.
- R2: A start pulse in idle sweeps codes 0, 1, 2, 3 in that order and issues exactly one read request per code. `dly_code_o` shows the trial code while its request is open, and `rt_req_o` stays high until `rt_done_i` is seen.
- R3: A code's pass bit is set only when `rt_data_i` equals `PATTERN` (default 16'h5AA5) in the cycle `rt_done_i` is high. A value that differs in any bit is a fail.
- R4: When exactly one code passes, that code is selected.
- R5: For two adjacent passes, the selection depends on the pair:
  - codes 0 and 1 select 0;
  - codes 1 and 2 select 1;
  - codes 2 and 3 select 3.
- R6: For three adjacent passes, codes 0 to 2 select 1 and codes 1 to 3 select 2.
- R7: When all four codes pass, code 1 is selected.
- R8: For a zero mask or a non-contiguous mask, `err_o` rises together with `done_o`, and both `dly_code_o` and `sel_code_o` go to 0.
- R9: On success, `done_o` is high for exactly one cycle with `err_o` low. `dly_code_o` and `sel_code_o` then carry the chosen code and hold it until the next start.
- R10: A start pulse while a calibration is in progress has no effect. The sweep still issues four requests and produces a single `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-calibration pulse |
| dly_code_o | output | 2 | Input delay code applied to the link |
| rt_req_o | output | 1 | Read-test request, held until done |
| rt_done_i | input | 1 | Read-test completion strobe |
| rt_data_i | input | 16 | Value returned by the read test |
| done_o | output | 1 | One-cycle calibration-finished pulse |
| err_o | output | 1 | Calibration failed, held until next start |
| sel_code_o | output | 2 | Selected delay code |

## Verification
The bench drives all sixteen pass masks, so every selection rule is exercised. A decoder that mixes up the boundary rule would pick 2 instead of 3 for codes 2 and 3. One that takes the upper middle would pick 2 instead of 1 when all four codes pass. A decoder that accepts gapped masks such as codes 0 and 2 would report success where an error is due.

A near-miss read value that differs from the pattern in one bit checks that the compare covers all 16 bits. A second start in the middle of a sweep checks that the sequencer does not restart, which would show up as extra requests or a second done pulse. After each result the bench watches that `dly_code_o` does not drift and that `done_o` does not stretch beyond one cycle.

// File: rtl/sdly_cal_pkg.sv
package sdly_cal_pkg;

    localparam int unsigned NUM_CODES = 4;
    localparam int unsigned CODE_W    = $clog2(NUM_CODES);

    typedef logic [CODE_W-1:0]    code_t;
    typedef logic [NUM_CODES-1:0] pass_mask_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_REQ,
        ST_DECIDE
    } cal_state_e;

    localparam code_t LAST_CODE = code_t'(NUM_CODES - 1);

endpackage

// File: rtl/sdly_cal_decode.sv
module sdly_cal_decode
    import sdly_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pass_mask_t mask_i,
    output logic       ok_o,
    output code_t      code_o
);

    always_comb begin
        ok_o   = 1'b1;
        code_o = '0;
        unique case (mask_i)
            // single pass
            4'b0001: code_o = 2'd0;
            4'b0010: code_o = 2'd1;
            4'b0100: code_o = 2'd2;
            4'b1000: code_o = 2'd3;
            // adjacent pair: edge of range, else lower
            4'b0011: code_o = 2'd0;
            4'b0110: code_o = 2'd1;
            4'b1100: code_o = 2'd3;
            // three in a row: middle
            4'b0111: code_o = 2'd1;
            4'b1110: code_o = 2'd2;
            // all four: lower middle
            4'b1111: code_o = 2'd1;
            default: begin
                ok_o   = 1'b0;
                code_o = '0;
            end
        endcase
    end

    // R4
    picked_code_passed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> mask_i[code_o]);

    // R8
    empty_mask_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> !ok_o);

endmodule

// File: rtl/sdly_cal_timer.sv
module sdly_cal_timer #(
    parameter int unsigned SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic zero_o
);

    localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 2);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(SETTLE_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdly_cal.sv
module sdly_cal
    import sdly_cal_pkg::*;
#(
    parameter logic [15:0] PATTERN    = 16'h5AA5,
    parameter int unsigned SETTLE_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic [1:0]  dly_code_o,
    output logic        rt_req_o,
    input  logic        rt_done_i,
    input  logic [15:0] rt_data_i,
    output logic        done_o,
    output logic        err_o,
    output logic [1:0]  sel_code_o
);

    cal_state_e state_q, state_d;
    code_t      dly_q, sel_q;
    pass_mask_t mask_q;
    logic       done_q, err_q;
    logic       tmr_load, tmr_zero;
    logic       dec_ok;
    code_t      dec_code;
    logic       match;

    assign match = (rt_data_i == PATTERN);

    sdly_cal_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .zero_o (tmr_zero)
    );

    sdly_cal_decode u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i (mask_q),
        .ok_o   (dec_ok),
        .code_o (dec_code)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                if (rt_done_i) begin
                    if (dly_q == LAST_CODE) begin
                        state_d = ST_DECIDE;
                    end else begin
                        state_d  = ST_SETTLE;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_DECIDE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q  <= '0;
            sel_q  <= '0;
            mask_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dly_q  <= '0;
                        mask_q <= '0;
                        err_q  <= 1'b0;
                    end
                end
                ST_REQ: begin
                    if (rt_done_i) begin
                        mask_q[dly_q] <= match;
                        if (dly_q != LAST_CODE) begin
                            dly_q <= dly_q + 1'b1;
                        end
                    end
                end
                ST_DECIDE: begin
                    done_q <= 1'b1;
                    err_q  <= !dec_ok;
                    sel_q  <= dec_ok ? dec_code : code_t'(0);
                    dly_q  <= dec_ok ? dec_code : code_t'(0);
                end
                default: ;
            endcase
        end
    end

    assign dly_code_o = dly_q;
    assign sel_code_o = sel_q;
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign rt_req_o   = (state_q == ST_REQ);

    // R2
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_req_o && !rt_done_i) |=> rt_req_o);

    // R2
    code_steps_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_req_o && rt_done_i && dly_code_o != LAST_CODE)
            |=> (dly_code_o == $past(dly_code_o) + 2'd1));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

    // R8
    err_dly_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (dly_code_o == 2'd0 && sel_code_o == 2'd0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> $stable(dly_code_o));

endmodule

// File: tb/sdly_cal_bench.sv
module sdly_cal_bench;

    localparam time         CLK_PERIOD = 10ns;
    localparam logic [15:0] PAT        = 16'h5AA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  dly_code_o;
    logic        rt_req_o;
    logic        rt_done_i = 1'b0;
    logic [15:0] rt_data_i = '0;
    logic        done_o;
    logic        err_o;
    logic [1:0]  sel_code_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [3:0] link_mask = 4'b0000;
    bit         near_miss = 1'b0;
    int         req_cnt = 0;
    logic [1:0] code_log [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdly_cal u_sdly_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dly_code_o (dly_code_o),
        .rt_req_o   (rt_req_o),
        .rt_done_i  (rt_done_i),
        .rt_data_i  (rt_data_i),
        .done_o     (done_o),
        .err_o      (err_o),
        .sel_code_o (sel_code_o)
    );

    // link model: answers each request after a small latency
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (rt_done_i) begin
                rt_done_i = 1'b0;
                rt_data_i = '0;
            end else if (rt_req_o) begin
                if (wait_cnt == 2) begin
                    wait_cnt = 0;
                    if (req_cnt < 4) code_log[req_cnt] = dly_code_o;
                    req_cnt++;
                    rt_done_i = 1'b1;
                    if (link_mask[dly_code_o]) rt_data_i = PAT;
                    else if (near_miss)        rt_data_i = PAT ^ 16'h0100;
                    else                       rt_data_i = ~PAT;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected result computed from the selection rules
    function automatic void expect_sel(input logic [3:0] m, output bit e_err,
                                       output int e_code, output string req);
        int n = 0;
        int lo = -1;
        int hi = -1;
        for (int i = 0; i < 4; i++) begin
            if (m[i]) begin
                n++;
                if (lo < 0) lo = i;
                hi = i;
            end
        end
        e_err = 1'b0;
        e_code = 0;
        if (n == 0 || (hi - lo + 1) != n) begin
            e_err = 1'b1;
            req = "R8";
        end else if (n == 1) begin
            e_code = lo;
            req = "R4";
        end else if (n == 2) begin
            e_code = (lo == 2) ? 3 : lo;
            req = "R5";
        end else if (n == 3) begin
            e_code = lo + 1;
            req = "R6";
        end else begin
            e_code = 1;
            req = "R7";
        end
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            if (done_o) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        check(done_o == 0 && err_o == 0 && rt_req_o == 0, "R1", "ctrl outs",
              {done_o, err_o, rt_req_o}, 0);
        check(dly_code_o == 0 && sel_code_o == 0, "R1", "codes",
              {dly_code_o, sel_code_o}, 0);
    endtask

    task automatic test_mask(input logic [3:0] m, input bit nm);
        bit seen;
        bit e_err;
        int e_code;
        string req;
        logic [1:0] held;
        link_mask = m;
        near_miss = nm;
        req_cnt = 0;
        expect_sel(m, e_err, e_code, req);
        pulse_start();
        wait_done(seen);
        check(seen, req, "done seen", seen, 1);
        if (!seen) return;
        check(req_cnt == 4, "R2", "request count", req_cnt, 4);
        for (int i = 0; i < 4; i++)
            check(code_log[i] == 2'(i), "R2", "trial code order", code_log[i], i);
        if (nm) req = "R3";
        check(err_o == e_err, req, "err", err_o, e_err);
        check(sel_code_o == 2'(e_code), req, "sel code", sel_code_o, e_code);
        check(dly_code_o == 2'(e_code), req, "dly code", dly_code_o, e_code);
        held = dly_code_o;
        @(negedge clk);
        check(done_o == 0, "R9", "done width", done_o, 0);
        repeat (5) @(negedge clk);
        check(dly_code_o == held && sel_code_o == held && err_o == e_err,
              "R9", "held result", dly_code_o, held);
    endtask

    task automatic test_busy_start();
        bit seen;
        int dones = 0;
        link_mask = 4'b1111;
        near_miss = 1'b0;
        req_cnt = 0;
        pulse_start();
        while (req_cnt < 2) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(seen);
        check(seen, "R10", "done seen", seen, 1);
        check(req_cnt == 4, "R10", "request count", req_cnt, 4);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        check(dones == 0 && req_cnt == 4, "R10", "extra done/requests",
              dones + req_cnt, 4);
        check(sel_code_o == 2'd1, "R10", "sel after ignored start", sel_code_o, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        for (int m = 0; m < 16; m++) test_mask(4'(m), 1'b0);
        test_mask(4'b0010, 1'b1);
        test_mask(4'b0000, 1'b1);
        test_busy_start();
        test_mask(4'b0101, 1'b0);
        test_mask(4'b1100, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule